// File: doc/BRIEF.md
# Virtualized Time Counter Offset Unit

This block sits in the control-register read path of a processor core with a hypervisor extension. It stores a 64-bit offset that host software programs. When the hart executes in a virtualized guest mode, a read of the time counter returns the free-running time value plus the stored offset. Reads from non-virtualized modes return the raw time. The host can therefore show each guest a shifted clock, and guest reads of time need no trap or emulation.

The unit has one control-register access port. The port carries a request, a write flag, a 12-bit address, the current privilege level, a virtualization flag and a narrow (32-bit) mode select. In 64-bit mode the offset is one register. In narrow mode the offset is split into a low-half register and a high-half register, and time is read as a low half and a high half of the full 64-bit sum. The carry from the low half is therefore visible in the high half. The read path is combinational. Writes update the offset on the next clock edge. Each access is classified into one of five kinds: none, offset-low, offset-high, time-low or time-high. The classification and an illegal-access flag come from a decode stage.

Top module: `vtime_offset`

## Requirements
- R1: After reset both offset halves are zero. An offset read returns 0, and a guest time read returns the raw time value.
- R2: With `virt_mode`=1 (virtual supervisor, `priv_lvl`=01, or virtual user, `priv_lvl`=00), a 64-bit-mode read of address 0xC01 returns (`time_now` + offset) mod 2^64.
- R3: With `virt_mode`=0, in any privilege level (U=00, S=01, M=11), a time read returns `time_now` unchanged.
- R4: In 64-bit mode (`narrow_mode`=0), address 0xA01 reads and writes all 64 offset bits.
- R5: In narrow mode, address 0xA01 holds offset bits 31:0 and 0xA81 holds offset bits 63:32. Writes take `csr_wdata`[31:0] and leave the other half unchanged. Reads return the half in bits 31:0 with bits 63:32 zero.
- R6: In 64-bit mode, an access to 0xA81 or to 0xC81 raises `csr_illegal`, returns 0 and changes nothing.
- R7: An offset access (0xA01 or 0xA81) with `virt_mode`=1, or with a privilege level other than S or M, raises `csr_illegal`. It returns 0 and leaves the offset unchanged.
- R8: In narrow mode, a guest read of 0xC01 returns bits 31:0 and a guest read of 0xC81 returns bits 63:32 of the 64-bit sum, including the carry out of the low half. Host reads return the matching halves of the raw time.
- R9: An offset write becomes visible from the next cycle. The data returned during the writing access is the old value.
- R10: A write to 0xC01 or 0xC81 is illegal and has no effect.
- R11: An address outside the four handled ones gives `csr_hit`=0, `csr_illegal`=0 and `csr_rdata`=0. `csr_hit` is 1 for exactly the four handled addresses when `csr_req`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_req | input | 1 | Access valid this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | Control-register address |
| csr_wdata | input | 64 | Write data |
| priv_lvl | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| virt_mode | input | 1 | Hart runs in a virtualized guest mode |
| narrow_mode | input | 1 | 1 selects 32-bit register width |
| time_now | input | 64 | Free-running time value |
| csr_rdata | output | 64 | Read data (0 when not hit or illegal) |
| csr_hit | output | 1 | Address is handled by this unit |
| csr_illegal | output | 1 | Access is not permitted |

## Verification
The hardest case to reach is a narrow-mode guest read of the upper time half whose value depends on a carry out of the low half. To produce it, the offset must first be assembled through two separate half writes, and the time value must be chosen so that its low half plus the offset low half overflows. The stimulus programs the low half near all-ones and the high half to a small value, then reads both time halves from guest and host modes at a time value just past the wrap point. A long run of mixed random accesses then repeats the same situation with arbitrary carries.

// File: rtl/vtime_pkg.sv
package vtime_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_DELTA_LO,
        ACC_DELTA_HI,
        ACC_TIME_LO,
        ACC_TIME_HI
    } acc_kind_e;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

endpackage

// File: rtl/vtime_decode.sv
module vtime_decode
    import vtime_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] ADDR_DLO = 12'hA01,
    parameter logic [ADDR_W-1:0] ADDR_DHI = 12'hA81,
    parameter logic [ADDR_W-1:0] ADDR_TLO = 12'hC01,
    parameter logic [ADDR_W-1:0] ADDR_THI = 12'hC81
) (
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        priv_i,
    input  logic              virt_i,
    input  logic              narrow_i,
    output acc_kind_e         kind_o,
    output logic              hit_o,
    output logic              illegal_o
);

    logic host_ok;
    logic deny;

    // Offset registers need host-level supervisor or machine privilege.
    assign host_ok = !virt_i && ((priv_i == PRIV_S) || (priv_i == PRIV_M));

    always_comb begin
        if (addr_i == ADDR_DLO)      kind_o = ACC_DELTA_LO;
        else if (addr_i == ADDR_DHI) kind_o = ACC_DELTA_HI;
        else if (addr_i == ADDR_TLO) kind_o = ACC_TIME_LO;
        else if (addr_i == ADDR_THI) kind_o = ACC_TIME_HI;
        else                         kind_o = ACC_NONE;
    end

    always_comb begin
        deny = 1'b0;
        unique case (kind_o)
            ACC_NONE:     deny = 1'b0;
            ACC_DELTA_LO: deny = !host_ok;
            ACC_DELTA_HI: deny = !host_ok || !narrow_i;
            ACC_TIME_LO:  deny = we_i;
            ACC_TIME_HI:  deny = we_i || !narrow_i;
            default:      deny = 1'b0;
        endcase
    end

    assign hit_o     = req_i && (kind_o != ACC_NONE);
    assign illegal_o = req_i && deny;

endmodule

// File: rtl/vtime_delta_regs.sv
module vtime_delta_regs #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_full_i,
    input  logic         wr_lo_i,
    input  logic         wr_hi_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] delta_o
);

    localparam int HW = W / 2;

    // One register per half; a full write loads both halves, a split
    // write loads one half from the low data lane.
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic          en;
        logic [HW-1:0] nxt;
        logic [HW-1:0] q;

        assign en  = wr_full_i || ((h == 0) ? wr_lo_i : wr_hi_i);
        assign nxt = wr_full_i ? wdata_i[h*HW +: HW] : wdata_i[HW-1:0];

        always_ff @(posedge clk) begin
            if (!rst_n)  q <= '0;
            else if (en) q <= nxt;
        end

        assign delta_o[h*HW +: HW] = q;
    end

    a_r5_hi_write_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_i && !wr_lo_i && !wr_full_i) |=> (delta_o[HW-1:0] == $past(delta_o[HW-1:0])));

    a_r5_lo_write_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !wr_hi_i && !wr_full_i) |=> (delta_o[W-1:HW] == $past(delta_o[W-1:HW])));

endmodule

// File: rtl/vtime_readout.sv
module vtime_readout
    import vtime_pkg::*;
#(
    parameter int W = 64
) (
    input  acc_kind_e    kind_i,
    input  logic         ok_i,
    input  logic         virt_i,
    input  logic         narrow_i,
    input  logic [W-1:0] time_i,
    input  logic [W-1:0] delta_i,
    output logic [W-1:0] rdata_o
);

    localparam int HW = W / 2;

    logic [W-1:0] seen_time;
    logic [W-1:0] sel;

    // Full-width sum wraps modulo 2^W; halves are cut from it afterwards
    // so the low-half carry reaches the upper half.
    assign seen_time = virt_i ? (time_i + delta_i) : time_i;

    always_comb begin
        sel = '0;
        unique case (kind_i)
            ACC_NONE:     sel = '0;
            ACC_DELTA_LO: sel = narrow_i ? {{HW{1'b0}}, delta_i[HW-1:0]} : delta_i;
            ACC_DELTA_HI: sel = {{HW{1'b0}}, delta_i[W-1:HW]};
            ACC_TIME_LO:  sel = narrow_i ? {{HW{1'b0}}, seen_time[HW-1:0]} : seen_time;
            ACC_TIME_HI:  sel = {{HW{1'b0}}, seen_time[W-1:HW]};
            default:      sel = '0;
        endcase
    end

    assign rdata_o = ok_i ? sel : '0;

endmodule

// File: rtl/vtime_offset.sv
module vtime_offset
    import vtime_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_req,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [TIME_W-1:0] csr_wdata,
    input  logic [1:0]        priv_lvl,
    input  logic              virt_mode,
    input  logic              narrow_mode,
    input  logic [TIME_W-1:0] time_now,
    output logic [TIME_W-1:0] csr_rdata,
    output logic              csr_hit,
    output logic              csr_illegal
);

    localparam logic [ADDR_W-1:0] A_DLO = ADDR_W'(12'hA01);
    localparam logic [ADDR_W-1:0] A_DHI = ADDR_W'(12'hA81);
    localparam logic [ADDR_W-1:0] A_TLO = ADDR_W'(12'hC01);
    localparam logic [ADDR_W-1:0] A_THI = ADDR_W'(12'hC81);

    acc_kind_e         kind;
    logic [TIME_W-1:0] delta_q;
    logic              legal_wr;
    logic              wr_full;
    logic              wr_lo;
    logic              wr_hi;

    vtime_decode #(
        .ADDR_W  (ADDR_W),
        .ADDR_DLO(A_DLO),
        .ADDR_DHI(A_DHI),
        .ADDR_TLO(A_TLO),
        .ADDR_THI(A_THI)
    ) u_decode (
        .req_i    (csr_req),
        .we_i     (csr_we),
        .addr_i   (csr_addr),
        .priv_i   (priv_lvl),
        .virt_i   (virt_mode),
        .narrow_i (narrow_mode),
        .kind_o   (kind),
        .hit_o    (csr_hit),
        .illegal_o(csr_illegal)
    );

    assign legal_wr = csr_req && csr_we && !csr_illegal;
    assign wr_full  = legal_wr && (kind == ACC_DELTA_LO) && !narrow_mode;
    assign wr_lo    = legal_wr && (kind == ACC_DELTA_LO) && narrow_mode;
    assign wr_hi    = legal_wr && (kind == ACC_DELTA_HI);

    vtime_delta_regs #(.W(TIME_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_full_i(wr_full),
        .wr_lo_i  (wr_lo),
        .wr_hi_i  (wr_hi),
        .wdata_i  (csr_wdata),
        .delta_o  (delta_q)
    );

    vtime_readout #(.W(TIME_W)) u_read (
        .kind_i  (kind),
        .ok_i    (csr_req && !csr_illegal),
        .virt_i  (virt_mode),
        .narrow_i(narrow_mode),
        .time_i  (time_now),
        .delta_i (delta_q),
        .rdata_o (csr_rdata)
    );

    a_r7_illegal_keeps_delta: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_illegal) |=> $stable(delta_q));

    a_r7_guest_offset_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && virt_mode && (csr_addr == A_DLO || csr_addr == A_DHI)) |-> csr_illegal);

    a_r6_wide_half_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !narrow_mode && (csr_addr == A_DHI || csr_addr == A_THI))
        |-> (csr_illegal && csr_rdata == '0));

    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_we && !csr_illegal && csr_addr == A_DLO && !narrow_mode)
        |=> (delta_q == $past(csr_wdata)));

    a_r3_raw_time: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !virt_mode && !csr_we && !narrow_mode && csr_addr == A_TLO)
        |-> (csr_rdata == time_now));

    a_r10_time_write_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_we && (csr_addr == A_TLO || csr_addr == A_THI)) |-> csr_illegal);

    a_r11_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !csr_hit) |-> (!csr_illegal && csr_rdata == '0));

endmodule

// File: tb/vtime_offset_test.sv
module vtime_offset_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_req = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [1:0]  priv_lvl = 2'b11;
    logic        virt_mode = 1'b0;
    logic        narrow_mode = 1'b0;
    logic [63:0] time_now = '0;
    logic [63:0] csr_rdata;
    logic        csr_hit;
    logic        csr_illegal;

    int checks = 0;
    int errors = 0;
    logic [63:0] m_delta = '0;

    always #10 clk = ~clk;

    vtime_offset uut (
        .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .priv_lvl(priv_lvl),
        .virt_mode(virt_mode), .narrow_mode(narrow_mode), .time_now(time_now),
        .csr_rdata(csr_rdata), .csr_hit(csr_hit), .csr_illegal(csr_illegal)
    );

    task automatic access(input string tag, input logic we, input logic [11:0] a,
                          input logic [1:0] p, input logic v, input logic n,
                          input logic [63:0] wd, input logic [63:0] t);
        logic        e_hit, e_ill, is_off, is_half, host;
        logic [63:0] e_rd, sum;
        @(negedge clk);
        csr_req = 1'b1; csr_we = we; csr_addr = a; priv_lvl = p;
        virt_mode = v; narrow_mode = n; csr_wdata = wd; time_now = t;
        #1;
        e_hit   = (a == 12'hA01) || (a == 12'hA81) || (a == 12'hC01) || (a == 12'hC81);
        is_off  = (a == 12'hA01) || (a == 12'hA81);
        is_half = (a == 12'hA81) || (a == 12'hC81);
        host    = !v && (p == 2'b01 || p == 2'b11);
        e_ill   = e_hit && ((is_half && !n) || (is_off && !host) || (!is_off && we));
        sum     = v ? t + m_delta : t;
        e_rd    = 64'd0;
        if (e_hit && !e_ill) begin
            if (a == 12'hA01)      e_rd = n ? {32'd0, m_delta[31:0]} : m_delta;
            else if (a == 12'hA81) e_rd = {32'd0, m_delta[63:32]};
            else if (a == 12'hC01) e_rd = n ? {32'd0, sum[31:0]} : sum;
            else                   e_rd = {32'd0, sum[63:32]};
        end
        checks++;
        if (csr_rdata !== e_rd || csr_hit !== e_hit || csr_illegal !== e_ill) begin
            errors++;
            $display("FAIL %s addr=%h: rdata=%h hit=%b ill=%b expected rdata=%h hit=%b ill=%b",
                     tag, a, csr_rdata, csr_hit, csr_illegal, e_rd, e_hit, e_ill);
        end
        @(posedge clk);
        if (we && e_hit && !e_ill && is_off) begin
            if (a == 12'hA81)   m_delta[63:32] = wd[31:0];
            else if (n)         m_delta[31:0]  = wd[31:0];
            else                m_delta        = wd;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset values
        access("R1", 0, 12'hA01, 2'b01, 0, 0, 0, 64'h1234);
        access("R1", 0, 12'hC01, 2'b01, 1, 0, 0, 64'h0000_0042_0000_1234);
        // R4 and R9: full write returns old value, new value next cycle
        access("R9", 1, 12'hA01, 2'b11, 0, 0, 64'h0000_0001_0000_0010, 64'h5);
        access("R4", 0, 12'hA01, 2'b01, 0, 0, 0, 64'h5);
        // R2: guest supervisor and guest user reads
        access("R2", 0, 12'hC01, 2'b01, 1, 0, 0, 64'h100);
        access("R2", 0, 12'hC01, 2'b00, 1, 0, 0, 64'hFFFF_FFFF_0000_0000);
        access("R2", 1, 12'hA01, 2'b01, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        access("R2", 0, 12'hC01, 2'b01, 1, 0, 0, 64'h5);
        // R3: host reads are raw
        access("R3", 0, 12'hC01, 2'b11, 0, 0, 0, 64'hABCD);
        access("R3", 0, 12'hC01, 2'b01, 0, 0, 0, 64'hABCD);
        access("R3", 0, 12'hC01, 2'b00, 0, 0, 0, 64'hABCD);
        // R7: guest or user offset access denied and no change
        access("R7", 1, 12'hA01, 2'b01, 1, 0, 64'h77, 64'h0);
        access("R7", 1, 12'hA01, 2'b00, 0, 0, 64'h77, 64'h0);
        access("R7", 0, 12'hA01, 2'b11, 1, 0, 0, 64'h0);
        access("R7", 0, 12'hA01, 2'b11, 0, 0, 0, 64'h0);
        // R6: upper halves do not exist in 64-bit mode
        access("R6", 1, 12'hA81, 2'b11, 0, 0, 64'h9, 64'h0);
        access("R6", 0, 12'hC81, 2'b11, 0, 0, 0, 64'h0);
        access("R6", 0, 12'hA01, 2'b11, 0, 0, 0, 64'h0);
        // R5: split halves in narrow mode
        access("R5", 1, 12'hA01, 2'b01, 0, 1, 64'hDEAD_BEEF_FFFF_FFF0, 64'h0);
        access("R5", 1, 12'hA81, 2'b01, 0, 1, 64'h1111_1111_0000_0002, 64'h0);
        access("R5", 0, 12'hA01, 2'b01, 0, 1, 0, 64'h0);
        access("R5", 0, 12'hA81, 2'b01, 0, 1, 0, 64'h0);
        access("R5", 0, 12'hA01, 2'b01, 0, 0, 0, 64'h0);
        // R8: carry from low half into high half
        access("R8", 0, 12'hC01, 2'b01, 1, 1, 0, 64'h0000_0000_0000_0020);
        access("R8", 0, 12'hC81, 2'b01, 1, 1, 0, 64'h0000_0000_0000_0020);
        access("R8", 0, 12'hC81, 2'b00, 1, 1, 0, 64'h0000_0005_FFFF_FFFF);
        access("R8", 0, 12'hC81, 2'b11, 0, 1, 0, 64'h0000_0005_FFFF_FFFF);
        access("R8", 0, 12'hC01, 2'b11, 0, 1, 0, 64'h0000_0005_FFFF_FFFF);
        // R10: time is read-only
        access("R10", 1, 12'hC01, 2'b11, 0, 0, 64'h1, 64'h3);
        access("R10", 1, 12'hC81, 2'b11, 0, 1, 64'h1, 64'h3);
        access("R10", 0, 12'hA01, 2'b11, 0, 0, 0, 64'h3);
        // R11: foreign addresses
        access("R11", 0, 12'h300, 2'b11, 0, 0, 0, 64'h3);
        access("R11", 1, 12'hA02, 2'b11, 0, 0, 64'h4, 64'h3);
        access("R11", 0, 12'hA01, 2'b11, 0, 0, 0, 64'h3);
        // Mixed random accesses covering all rules
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            logic [1:0]  p;
            case ($urandom_range(0, 4))
                0: a = 12'hA01;
                1: a = 12'hA81;
                2: a = 12'hC01;
                3: a = 12'hC81;
                default: a = 12'h7C0;
            endcase
            p = 2'($urandom_range(0, 3));
            access("RND", 1'($urandom_range(0, 1)), a, p, 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), {$urandom, $urandom}, {$urandom, $urandom});
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule